// File: doc/BRIEF.md
# LAPS Transmit Frame Encapsulator

This block turns a stream of Ethernet MAC frames into LAPS-framed octets for a SONET/SDH payload. MAC frame octets come in from a transmit FIFO on a valid/ready octet interface, with a marker on the final octet of each packet. The first valid octet after a packet end starts the next packet. On the line side, a consumer takes one octet in every cycle in which it raises `out_ready`. The block always presents an octet. Between packets that octet is a 0x7E fill flag.

For each packet the block sends an opening 0x7E flag, followed by an optional header. The header holds an address octet (0x04), a control octet (0x03) and a two-octet SAPI (0xFE, then 0x01). The MAC octets follow, then an optional 32-bit FCS and an optional closing 0x7E flag. Static configuration inputs enable or disable each optional field. Between the flags, any octet equal to 0x7E or 0x7D goes out as a two-octet escape pair, and this includes header and FCS octets. A one-cycle request pulse corrupts the FCS of the next frame for link testing. A configuration input selects how the block reacts when the FIFO runs dry in the middle of a packet.

Top module: `laps_tx_encap`

## Requirements
- R1: During reset, and whenever no packet is in progress, `out_data` is 0x7E and `in_ready` is low.
- R2: A frame goes out as: 0x7E, then the enabled header octets in the order 0x04, 0x03, 0xFE, 0x01, then every input octet of the packet in arrival order, then the enabled FCS octets, then the closing 0x7E if it is enabled.
- R3: `cfg_addr_en`, `cfg_ctrl_en`, `cfg_sapi_en` (both SAPI octets together), `cfg_fcs_en` and `cfg_eflag_en` each remove their own field when low. The opening flag is always sent.
- R4: The FCS is CRC-32 with generator 0x04C11DB7, processed LSB first, preset to all ones and complemented at the end. It covers the enabled header octets and the payload, and it is sent as four octets, least significant octet first.
- R5: Inside a frame (header, payload and FCS), an octet 0x7E is sent as 0x7D 0x5E and an octet 0x7D is sent as 0x7D 0x5D. Flags, fill and the abort sequence are never escaped.
- R6: A one-cycle pulse on `fcs_err_req` inverts bit 0 of the last FCS octet of the next frame that sends an FCS. Later frames carry a correct FCS.
- R7: With `cfg_uf_hold` low, if the FIFO is empty when the next payload octet is due, the block sends 0x7D 0x7E, returns to fill, and discards input octets up to and including the next one marked last.
- R8: With `cfg_uf_hold` high, if the FIFO is empty in mid-packet, the block sends 0x7E fill octets inside the frame until data resumes. The frame then completes normally with an FCS computed only over the real octets.
- R9: While `out_ready` is low, the frame does not advance and `in_ready` is low. Each input octet is taken exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input octet present |
| in_data | input | 8 | Input MAC frame octet |
| in_last | input | 1 | Marks the final octet of a packet |
| in_ready | output | 1 | Block takes the input octet this cycle |
| out_data | output | 8 | Line-side octet presented this cycle |
| out_ready | input | 1 | Line side takes `out_data` this cycle |
| cfg_addr_en | input | 1 | Send the address octet |
| cfg_ctrl_en | input | 1 | Send the control octet |
| cfg_sapi_en | input | 1 | Send the two SAPI octets |
| cfg_fcs_en | input | 1 | Send the 32-bit FCS |
| cfg_eflag_en | input | 1 | Send the closing flag |
| cfg_uf_hold | input | 1 | Underflow response: 0 abort, 1 fill inside frame |
| fcs_err_req | input | 1 | Pulse: corrupt the next transmitted FCS |

## Verification
Two situations are hard to reach from the ports. The first is a FIFO underflow in mid-packet. The bench reaches it by withholding `in_valid` for several cycles after a chosen number of payload octets while `out_ready` stays high, and it runs this once under each underflow mode. The second is an FCS that itself contains a flag or escape value. The bench finds one by searching over the last two payload octets until its own CRC model yields such an octet, then sends that packet. Every line-side octet is compared against a queue that the bench model builds from the requirements. Fill octets are tolerated only where the requirements allow them.

// File: rtl/laps_tx_pkg.sv
package laps_tx_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [7:0] LAPS_FLAG     = 8'h7E;
   localparam logic [7:0] LAPS_ESC      = 8'h7D;
   localparam logic [7:0] LAPS_ESC_MASK = 8'h20;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HDR   = 3'd1,
      ST_DATA  = 3'd2,
      ST_FCS   = 3'd3,
      ST_EFLAG = 3'd4,
      ST_ABORT = 3'd5
   } laps_st_e;
endpackage

// File: rtl/laps_crc32.sv
module laps_crc32 #(
   parameter int          CRC_W  = 32,
   parameter int          OCT_W  = 8,
   parameter logic [31:0] POLY_R = 32'hEDB88320
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [OCT_W-1:0] din,
   output logic [CRC_W-1:0] fcs
);
   timeunit 1ns;
   timeprecision 1ps;

   if (CRC_W != 32) begin : g_bad_w
      $error("laps_crc32 supports only a 32-bit CRC");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;

   always_comb begin
      crc_nxt = crc_q;
      for (int b = 0; b < OCT_W; b++) begin
         if (crc_nxt[0] ^ din[b]) crc_nxt = (crc_nxt >> 1) ^ POLY_R[CRC_W-1:0];
         else                     crc_nxt = crc_nxt >> 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= '1;
      else if (clr) crc_q <= '1;
      else if (en)  crc_q <= crc_nxt;
   end

   assign fcs = ~crc_q;
endmodule

// File: rtl/laps_hdr_seq.sv
module laps_hdr_seq #(
   parameter  int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  mask,
   input  logic [IW-1:0] cur,
   output logic [IW-1:0] first_idx,
   output logic          first_ok,
   output logic [IW-1:0] next_idx,
   output logic          next_ok
);
   timeunit 1ns;
   timeprecision 1ps;

   always_comb begin
      first_ok  = 1'b0;
      first_idx = '0;
      next_ok   = 1'b0;
      next_idx  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) begin
            first_ok  = 1'b1;
            first_idx = IW'(i);
         end
         if (mask[i] && (i > int'(cur))) begin
            next_ok  = 1'b1;
            next_idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/laps_stuffer.sv
module laps_stuffer #(
   parameter int             OCT_W    = 8,
   parameter bit             STUFF_EN = 1'b1,
   parameter logic [OCT_W-1:0] FLAG   = 8'h7E,
   parameter logic [OCT_W-1:0] ESC    = 8'h7D,
   parameter logic [OCT_W-1:0] MASK   = 8'h20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCT_W-1:0] cur,
   input  logic             cur_stf,
   input  logic             take,
   output logic [OCT_W-1:0] dout,
   output logic             pend
);
   timeunit 1ns;
   timeprecision 1ps;

   if (STUFF_EN) begin : g_stuff
      logic             pend_q;
      logic [OCT_W-1:0] held_q;
      logic             hit;

      assign hit = cur_stf && ((cur == FLAG) || (cur == ESC));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            held_q <= '0;
         end else if (take) begin
            if (pend_q) begin
               pend_q <= 1'b0;
            end else if (hit) begin
               pend_q <= 1'b1;
               held_q <= cur;
            end
         end
      end

      assign dout = pend_q ? (held_q ^ MASK) : (hit ? ESC : cur);
      assign pend = pend_q;
   end else begin : g_pass
      assign dout = cur;
      assign pend = 1'b0;
   end
endmodule

// File: rtl/laps_tx_encap.sv
module laps_tx_encap
   import laps_tx_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  ADDR_OCT = 8'h04,
   parameter logic [7:0]  CTRL_OCT = 8'h03,
   parameter logic [15:0] SAPI_VAL = 16'hFE01,
   parameter int          FCS_W    = 32,
   parameter bit          STUFF_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready,
   input  logic              cfg_addr_en,
   input  logic              cfg_ctrl_en,
   input  logic              cfg_sapi_en,
   input  logic              cfg_fcs_en,
   input  logic              cfg_eflag_en,
   input  logic              cfg_uf_hold,
   input  logic              fcs_err_req
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int HDR_LEN   = 4;
   localparam int HIDX_W    = $clog2(HDR_LEN);
   localparam int FCS_OCTS  = FCS_W / DATA_W;
   localparam int FIDX_W    = $clog2(FCS_OCTS);
   localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(FCS_OCTS - 1);

   if (DATA_W != 8) begin : g_bad_dw
      $error("laps_tx_encap requires an 8-bit octet path");
   end
   if (FCS_W != 32) begin : g_bad_fcs
      $error("laps_tx_encap requires a 32-bit FCS");
   end

   laps_st_e          st;
   logic [HIDX_W-1:0] hidx;
   logic [FIDX_W-1:0] fidx;
   logic              drain;
   logic              inj_armed;

   logic              esc_pend;
   logic              adv;
   logic [DATA_W-1:0] cur_oct;
   logic              cur_stf;
   logic [DATA_W-1:0] hdr_oct;
   logic [DATA_W-1:0] fcs_oct;
   logic [FCS_W-1:0]  fcs_word;

   logic [HDR_LEN-1:0] hdr_mask;
   logic [HIDX_W-1:0]  first_idx, next_idx;
   logic               first_ok, next_ok;

   logic              crc_clr, crc_en;
   logic [DATA_W-1:0] crc_din;

   assign adv      = out_ready && !esc_pend;
   assign hdr_mask = {cfg_sapi_en, cfg_sapi_en, cfg_ctrl_en, cfg_addr_en};

   laps_hdr_seq #(.N(HDR_LEN)) u_hdr_seq (
      .mask      (hdr_mask),
      .cur       (hidx),
      .first_idx (first_idx),
      .first_ok  (first_ok),
      .next_idx  (next_idx),
      .next_ok   (next_ok)
   );

   always_comb begin
      unique case (hidx)
         2'd0:    hdr_oct = ADDR_OCT;
         2'd1:    hdr_oct = CTRL_OCT;
         2'd2:    hdr_oct = SAPI_VAL[15:8];
         default: hdr_oct = SAPI_VAL[7:0];
      endcase
   end

   assign crc_clr = adv && (st == ST_IDLE) && !drain && in_valid;
   assign crc_en  = adv && ((st == ST_HDR) || ((st == ST_DATA) && in_valid));
   assign crc_din = (st == ST_HDR) ? hdr_oct : in_data;

   laps_crc32 #(.CRC_W(FCS_W), .OCT_W(DATA_W)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .en    (crc_en),
      .din   (crc_din),
      .fcs   (fcs_word)
   );

   always_comb begin
      fcs_oct = fcs_word[DATA_W*fidx +: DATA_W];
      if ((fidx == FIDX_LAST) && inj_armed) fcs_oct[0] = ~fcs_oct[0];
   end

   always_comb begin
      cur_oct = LAPS_FLAG;
      cur_stf = 1'b0;
      unique case (st)
         ST_HDR: begin
            cur_oct = hdr_oct;
            cur_stf = 1'b1;
         end
         ST_DATA: begin
            if (in_valid) begin
               cur_oct = in_data;
               cur_stf = 1'b1;
            end else begin
               cur_oct = cfg_uf_hold ? LAPS_FLAG : LAPS_ESC;
            end
         end
         ST_FCS: begin
            cur_oct = fcs_oct;
            cur_stf = 1'b1;
         end
         default: ;
      endcase
   end

   laps_stuffer #(
      .OCT_W    (DATA_W),
      .STUFF_EN (STUFF_EN),
      .FLAG     (LAPS_FLAG),
      .ESC      (LAPS_ESC),
      .MASK     (LAPS_ESC_MASK)
   ) u_stuff (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur     (cur_oct),
      .cur_stf (cur_stf),
      .take    (out_ready),
      .dout    (out_data),
      .pend    (esc_pend)
   );

   assign in_ready = adv && ((st == ST_DATA) || ((st == ST_IDLE) && drain));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         hidx      <= '0;
         fidx      <= '0;
         drain     <= 1'b0;
         inj_armed <= 1'b0;
      end else begin
         if (fcs_err_req)
            inj_armed <= 1'b1;
         else if (adv && (st == ST_FCS) && (fidx == FIDX_LAST))
            inj_armed <= 1'b0;

         if (adv) begin
            unique case (st)
               ST_IDLE: begin
                  if (drain) begin
                     if (in_valid && in_last) drain <= 1'b0;
                  end else if (in_valid) begin
                     if (first_ok) begin
                        st   <= ST_HDR;
                        hidx <= first_idx;
                     end else begin
                        st <= ST_DATA;
                     end
                  end
               end
               ST_HDR: begin
                  if (next_ok) hidx <= next_idx;
                  else         st   <= ST_DATA;
               end
               ST_DATA: begin
                  if (in_valid) begin
                     if (in_last) begin
                        fidx <= '0;
                        if (cfg_fcs_en)        st <= ST_FCS;
                        else if (cfg_eflag_en) st <= ST_EFLAG;
                        else                   st <= ST_IDLE;
                     end
                  end else if (!cfg_uf_hold) begin
                     st    <= ST_ABORT;
                     drain <= 1'b1;
                  end
               end
               ST_FCS: begin
                  if (fidx == FIDX_LAST) st <= cfg_eflag_en ? ST_EFLAG : ST_IDLE;
                  else                   fidx <= fidx + 1'b1;
               end
               ST_EFLAG: st <= ST_IDLE;
               ST_ABORT: st <= ST_IDLE;
               default:  st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/laps_tx_encap_chk.sv
module laps_tx_encap_chk
   import laps_tx_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       out_ready,
   input logic       in_ready,
   input logic [7:0] out_data,
   input laps_st_e   st,
   input logic       esc_pend
);
   timeunit 1ns;
   timeprecision 1ps;

   a_r9_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> !in_ready);

   a_r9_take_slot: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (out_ready && !esc_pend && (st == ST_DATA || st == ST_IDLE)));

   a_r1_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !esc_pend) |-> out_data == 8'h7E);

   a_r5_esc_lead: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(esc_pend) |-> ($past(out_data) == 8'h7D && $past(out_ready)));

   a_r5_esc_code: assert property (@(posedge clk) disable iff (!rst_n)
      esc_pend |-> (out_data == 8'h5E || out_data == 8'h5D));

   a_r7_abort_mark: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_ABORT) |-> ($past(out_data) == 8'h7D && $past(out_ready)));

   a_r7_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ABORT) |-> out_data == 8'h7E);
endmodule

bind laps_tx_encap laps_tx_encap_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_ready (out_ready),
   .in_ready  (in_ready),
   .out_data  (out_data),
   .st        (st),
   .esc_pend  (esc_pend)
);

// File: tb/laps_tx_encap_tb.sv
module laps_tx_encap_tb;
   timeunit 1ns;
   timeprecision 1ps;

   typedef logic [7:0] oct_q_t [$];

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0, fcs_err_req = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic [7:0] out_data;
   logic       in_ready;
   logic       cfg_addr_en = 1'b1, cfg_ctrl_en = 1'b1, cfg_sapi_en = 1'b1;
   logic       cfg_fcs_en = 1'b1, cfg_eflag_en = 1'b1, cfg_uf_hold = 1'b0;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   logic [7:0] expq [$];
   bit         endq [$];
   bit         in_frame = 1'b0;
   bit         mon_en = 1'b0;
   bit         done = 1'b0;
   int         or_mode = 2;
   logic [15:0] lfsr = 16'hACE1;

   laps_tx_encap u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_data      (in_data),
      .in_last      (in_last),
      .in_ready     (in_ready),
      .out_data     (out_data),
      .out_ready    (out_ready),
      .cfg_addr_en  (cfg_addr_en),
      .cfg_ctrl_en  (cfg_ctrl_en),
      .cfg_sapi_en  (cfg_sapi_en),
      .cfg_fcs_en   (cfg_fcs_en),
      .cfg_eflag_en (cfg_eflag_en),
      .cfg_uf_hold  (cfg_uf_hold),
      .fcs_err_req  (fcs_err_req)
   );

   task automatic fail(input string req, input logic [7:0] act, input logic [7:0] exp_v);
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp_v, $time);
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // line-side pacing
   initial begin
      forever begin
         @(posedge clk);
         #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (or_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[0] | lfsr[5];
            default: out_ready = 1'b0;
         endcase
      end
   end

   // reference CRC-32, whole-octet xor form
   function automatic logic [31:0] crc32(input oct_q_t d);
      logic [31:0] c = 32'hFFFF_FFFF;
      foreach (d[i]) begin
         c = c ^ {24'd0, d[i]};
         repeat (8) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return ~c;
   endfunction

   function automatic oct_q_t hdr_list();
      oct_q_t h;
      if (cfg_addr_en) h.push_back(8'h04);
      if (cfg_ctrl_en) h.push_back(8'h03);
      if (cfg_sapi_en) begin
         h.push_back(8'hFE);
         h.push_back(8'h01);
      end
      return h;
   endfunction

   function automatic oct_q_t mk(input int n, input int seed);
      oct_q_t q;
      for (int i = 0; i < n; i++) q.push_back(8'((seed * 29 + i * 13 + i * i) & 255));
      return q;
   endfunction

   function automatic void push_oct(input logic [7:0] v, input bit stf, input bit last);
      if (stf && (v == 8'h7E || v == 8'h7D)) begin
         expq.push_back(8'h7D);       endq.push_back(1'b0);
         expq.push_back(v ^ 8'h20);   endq.push_back(last);
      end else begin
         expq.push_back(v);           endq.push_back(last);
      end
   endfunction

   // expected frame from the requirements; abort_k >= 0 means a mode-0 abort after k octets
   function automatic void build_exp(input oct_q_t p, input int abort_k, input bit inj);
      oct_q_t h = hdr_list();
      oct_q_t d = h;
      logic [31:0] f;
      logic [7:0]  b;
      foreach (p[i]) d.push_back(p[i]);
      f = crc32(d);
      push_oct(8'h7E, 1'b0, 1'b0);
      foreach (h[i]) push_oct(h[i], 1'b1, 1'b0);
      if (abort_k >= 0) begin
         for (int i = 0; i < abort_k; i++) push_oct(p[i], 1'b1, 1'b0);
         push_oct(8'h7D, 1'b0, 1'b0);
         push_oct(8'h7E, 1'b0, 1'b1);
         return;
      end
      foreach (p[i])
         push_oct(p[i], 1'b1, (i == p.size() - 1) && !cfg_fcs_en && !cfg_eflag_en);
      if (cfg_fcs_en) begin
         for (int k = 0; k < 4; k++) begin
            b = f[8*k +: 8];
            if (k == 3 && inj) b[0] = ~b[0];
            push_oct(b, 1'b1, (k == 3) && !cfg_eflag_en);
         end
      end
      if (cfg_eflag_en) push_oct(8'h7E, 1'b0, 1'b1);
   endfunction

   task automatic chk_octet(input logic [7:0] a);
      logic [7:0] e;
      bit         l;
      checks++;
      if (!in_frame) begin
         if (a == 8'h7E) return;
         if (expq.size() == 0) begin
            fail({cur_req, " (R1 fill)"}, a, 8'h7E);
            return;
         end
         void'(expq.pop_front());
         void'(endq.pop_front());
         in_frame = 1'b1;
      end else if (a == 8'h7E && expq.size() > 0 && expq[0] != 8'h7E) begin
         if (!cfg_uf_hold) fail({cur_req, " (R8 fill not allowed)"}, a, expq[0]);
         return;
      end
      if (expq.size() == 0) begin
         fail(cur_req, a, 8'h7E);
         in_frame = 1'b0;
         return;
      end
      e = expq.pop_front();
      l = endq.pop_front();
      if (a !== e) fail(cur_req, a, e);
      if (l) in_frame = 1'b0;
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         if (!out_ready) begin
            checks++;
            if (in_ready !== 1'b0) fail("R9 in_ready while stalled", {7'd0, in_ready}, 8'h00);
         end else begin
            chk_octet(out_data);
         end
      end
   end

   task automatic send_pkt(input oct_q_t q, input int stall_at, input int stall_len);
      bit fire;
      for (int i = 0; i < q.size(); i++) begin
         if (i == stall_at) begin
            in_valid = 1'b0;
            in_last  = 1'b0;
            repeat (stall_len) @(posedge clk);
            #1;
         end
         in_valid = 1'b1;
         in_data  = q[i];
         in_last  = (i == q.size() - 1);
         do begin
            @(negedge clk);
            fire = in_ready;
            @(posedge clk);
            #1;
         end while (!fire);
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic wait_idle();
      while (expq.size() != 0 || in_frame) begin
         @(posedge clk);
         #1;
      end
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic run_frame(input oct_q_t p, input int stall_at, input int stall_len,
                            input bit inj, input string req);
      cur_req = req;
      build_exp(p, (stall_at >= 0 && !cfg_uf_hold) ? stall_at : -1, inj);
      if (inj) begin
         fcs_err_req = 1'b1;
         @(posedge clk);
         #1;
         fcs_err_req = 1'b0;
      end
      send_pkt(p, stall_at, stall_len);
      wait_idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         report();
      end
   end

   initial begin
      oct_q_t p;
      oct_q_t hd;
      logic [31:0] f;

      // R1: reset state
      repeat (2) @(negedge clk);
      checks++; if (out_data !== 8'h7E) fail("R1 reset out_data", out_data, 8'h7E);
      checks++; if (in_ready !== 1'b0)  fail("R1 reset in_ready", {7'd0, in_ready}, 8'h00);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      or_mode = 0;
      repeat (3) @(negedge clk);
      checks++; if (out_data !== 8'h7E) fail("R1 idle out_data", out_data, 8'h7E);
      checks++; if (in_ready !== 1'b0)  fail("R1 idle in_ready", {7'd0, in_ready}, 8'h00);
      @(posedge clk);
      #1;
      mon_en = 1'b1;

      // R2 R4 R5: full frame with flag and escape values in the payload
      p = mk(24, 1);
      p[2] = 8'h7E; p[5] = 8'h7D; p[23] = 8'h7E;
      run_frame(p, -1, 0, 1'b0, "R2 R4 R5 full frame");

      // R9: irregular line-side pacing
      or_mode = 1;
      p = mk(40, 3);
      p[0] = 8'h7D; p[17] = 8'h7E;
      run_frame(p, -1, 0, 1'b0, "R9 paced frame");
      p = mk(9, 8);
      run_frame(p, -1, 0, 1'b0, "R9 paced short frame");
      or_mode = 0;

      // R3: field disables
      cfg_addr_en = 1'b0;
      run_frame(mk(12, 4), -1, 0, 1'b0, "R3 no address");
      cfg_addr_en = 1'b1; cfg_ctrl_en = 1'b0; cfg_sapi_en = 1'b0;
      run_frame(mk(12, 5), -1, 0, 1'b0, "R3 no control no SAPI");
      cfg_ctrl_en = 1'b1; cfg_sapi_en = 1'b1; cfg_fcs_en = 1'b0;
      run_frame(mk(10, 6), -1, 0, 1'b0, "R3 no FCS");
      cfg_fcs_en = 1'b1; cfg_eflag_en = 1'b0;
      run_frame(mk(10, 7), -1, 0, 1'b0, "R3 no end flag");
      run_frame(mk(11, 9), -1, 0, 1'b0, "R3 back-to-back no end flag");
      cfg_addr_en = 1'b0; cfg_ctrl_en = 1'b0; cfg_sapi_en = 1'b0; cfg_fcs_en = 1'b0;
      p = mk(8, 10);
      p[7] = 8'h7D;
      run_frame(p, -1, 0, 1'b0, "R3 R5 bare payload ending in escape");
      cfg_addr_en = 1'b1; cfg_ctrl_en = 1'b1; cfg_sapi_en = 1'b1;
      cfg_fcs_en = 1'b1; cfg_eflag_en = 1'b1;
      run_frame(mk(6, 11), -1, 0, 1'b0, "R3 all fields restored");

      // R5 R4: FCS holding a flag or escape value
      p = mk(14, 12);
      p.push_back(8'h00);
      p.push_back(8'h00);
      hd = hdr_list();
      for (int j = 0; j < 65536; j++) begin
         oct_q_t d;
         p[14] = j[15:8];
         p[15] = j[7:0];
         d = hd;
         foreach (p[i]) d.push_back(p[i]);
         f = crc32(d);
         if (f[7:0] == 8'h7E || f[7:0] == 8'h7D || f[15:8] == 8'h7E || f[15:8] == 8'h7D ||
             f[23:16] == 8'h7E || f[23:16] == 8'h7D || f[31:24] == 8'h7E || f[31:24] == 8'h7D)
            break;
      end
      run_frame(p, -1, 0, 1'b0, "R5 R4 escaped FCS octet");

      // R6: FCS error injection, once
      run_frame(mk(16, 13), -1, 0, 1'b1, "R6 injected FCS error");
      run_frame(mk(16, 13), -1, 0, 1'b0, "R6 following frame clean");

      // R7: underflow abort, drain, then a clean frame
      cfg_uf_hold = 1'b0;
      p = mk(12, 14);
      p[4] = 8'h7E;
      run_frame(p, 5, 4, 1'b0, "R7 underflow abort");
      run_frame(mk(10, 15), -1, 0, 1'b0, "R7 frame after drain");

      // R8: underflow held inside the frame
      cfg_uf_hold = 1'b1;
      p = mk(14, 16);
      p[6] = 8'h7E;
      run_frame(p, 6, 5, 1'b0, "R8 underflow fill");
      run_frame(mk(10, 17), 3, 2, 1'b0, "R8 short gap");
      cfg_uf_hold = 1'b0;

      done = 1'b1;
      mon_en = 1'b0;
      report();
   end
endmodule